// File: doc/BRIEF.md
# MSI Snooping Cache Line Controller

This block is the coherence controller of a small direct-mapped private cache on a shared snooping bus. It keeps a tag, a one-word data value and an MSI state (Invalid, Shared or Modified) for every line. It serves read and write requests from its own core. It also watches the transactions that other caches put on the bus. When a core request cannot finish locally, the controller asks an external arbiter for the bus and places one transaction. That transaction is a read miss, a write miss, an invalidate, or the write-back of a dirty victim. It then waits for the bus acknowledge. When a snooped request hits a Modified line, the controller drives the line's data out and updates the line's state in the same cycle.

The core holds `core_valid` high with its request until `core_ready` pulses. `core_ready` completes a hit in the same cycle, and the read data is valid in that cycle. The controller has three states:

- **CT_IDLE** looks the request up. A hit completes at once. A miss, or a write to a Shared line, takes the transition IDLE→REQ.
- **CT_REQ** holds `bus_req`. It decides which command it needs from the line's current state, so a snoop that arrives while it waits changes that decision. On grant it takes REQ→BUSY and latches the command.
- **CT_BUSY** drives the command, with a one-cycle `bus_valid` that other caches snoop. On `bus_ack` it applies the line update and takes BUSY→IDLE. IDLE then looks the request up again.

A transaction that needs two bus steps (victim write-back, then miss) therefore goes round IDLE→REQ→BUSY twice.

Top module: `msi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, `bus_req`, `bus_valid` and `core_ready` are low, and the first access to any address goes to the bus.
- R2: A core read that hits a Shared or Modified line, and a core write that hits a Modified line, assert `core_ready` in the cycle they are presented, with no bus transaction.
- R3: A core write that hits a Shared line places an invalidate (command 3) for the request address, then the line becomes Modified and the write completes.
- R4: On a core miss whose victim line is Modified, a write-back (command 4) carrying the victim's address and data is placed first, and the read or write miss follows as a separate transaction.
- R5: A read miss (command 1) fills the line as Shared; a write miss (command 2) fills it as Modified, so a following write to it needs no bus transaction.
- R6: A snooped read miss that hits a Shared line has no effect: `snp_flush` stays low and the line stays readable without bus traffic.
- R7: A snooped read miss that hits a Modified line raises `snp_flush` with the line data on `snp_data` in the snoop cycle, and the line becomes Shared.
- R8: A snooped invalidate or write miss that hits a Shared line makes it Invalid. A snooped write miss that hits a Modified line first supplies the data through `snp_flush`/`snp_data`, then makes it Invalid.
- R9: Only the grant holder drives the bus. When two caches upgrade the same Shared line at once, the loser's line is invalidated by the winner's invalidate, and the loser then issues a write miss instead of an invalidate.
- R10: While a core request needs the bus, `core_ready` stays low and `bus_req` stays high until `bus_ack`. A snoop has priority: no core request completes in a cycle with `snp_valid` high.
- R11: Bus commands use the encoding none=0, read miss=1, write miss=2, invalidate=3, write-back=4. `bus_valid` is a one-cycle pulse in the first cycle of ownership, and only while `bus_gnt` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_valid | input | 1 | Core request present, held until ready |
| core_write | input | 1 | 1 = write, 0 = read |
| core_addr | input | ADDR_W | Word address; low bits index the line |
| core_wdata | input | DATA_W | Write data |
| core_ready | output | 1 | Request completes this cycle |
| core_rdata | output | DATA_W | Read data, valid with core_ready |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant |
| bus_valid | output | 1 | First-cycle strobe of an own transaction |
| bus_cmd | output | 3 | Own transaction command |
| bus_addr | output | ADDR_W | Own transaction address |
| bus_wdata | output | DATA_W | Write-back data |
| bus_ack | input | 1 | Own transaction completed |
| bus_rdata | input | DATA_W | Fill data for a miss, valid with bus_ack |
| snp_valid | input | 1 | Another cache's transaction strobe |
| snp_cmd | input | 3 | Snooped command |
| snp_addr | input | ADDR_W | Snooped address |
| snp_flush | output | 1 | This cache supplies dirty data for the snoop |
| snp_data | output | DATA_W | Supplied line data |

## Verification
The hardest case to reach is two cores writing the same Shared line at the same moment. The losing controller must find its line invalidated while it is still waiting in REQ, and must change its pending upgrade into a write miss. The bench first loads the line as Shared in both caches. It then starts both writes in the same cycle, with a fixed-priority arbiter, so the winner's invalidate lands while the other cache's request is outstanding. The order of commands is then checked from a bus log, and the final value is checked by reading back through the winner.

// File: rtl/msi_pkg.sv
package msi_pkg;
    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_SHR = 2'd1,
        LN_MOD = 2'd2
    } line_st_e;

    typedef enum logic [2:0] {
        BC_NONE   = 3'd0,
        BC_RDMISS = 3'd1,
        BC_WRMISS = 3'd2,
        BC_INV    = 3'd3,
        BC_WB     = 3'd4
    } bus_cmd_e;

    typedef enum logic [1:0] {
        CT_IDLE = 2'd0,
        CT_REQ  = 2'd1,
        CT_BUSY = 2'd2
    } ctl_st_e;
endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
    import msi_pkg::*;
#(
    parameter int LINES  = 4,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(LINES)-1:0] ra_idx,
    output line_st_e                 ra_state,
    output logic [TAG_W-1:0]         ra_tag,
    output logic [DATA_W-1:0]        ra_data,
    input  logic [$clog2(LINES)-1:0] rb_idx,
    output line_st_e                 rb_state,
    output logic [TAG_W-1:0]         rb_tag,
    output logic [DATA_W-1:0]        rb_data,
    input  logic                     we,
    input  logic [$clog2(LINES)-1:0] w_idx,
    input  line_st_e                 w_state,
    input  logic                     w_tag_en,
    input  logic [TAG_W-1:0]         w_tag,
    input  logic                     w_data_en,
    input  logic [DATA_W-1:0]        w_data
);
    line_st_e          st_q   [LINES];
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q[g]   <= LN_INV;
                tag_q[g]  <= '0;
                data_q[g] <= '0;
            end else if (we && (w_idx == g)) begin
                st_q[g] <= w_state;
                if (w_tag_en)  tag_q[g]  <= w_tag;
                if (w_data_en) data_q[g] <= w_data;
            end
        end
    end

    assign ra_state = st_q[ra_idx];
    assign ra_tag   = tag_q[ra_idx];
    assign ra_data  = data_q[ra_idx];
    assign rb_state = st_q[rb_idx];
    assign rb_tag   = tag_q[rb_idx];
    assign rb_data  = data_q[rb_idx];
endmodule

// File: rtl/msi_snoop_resp.sv
module msi_snoop_resp
    import msi_pkg::*;
#(
    parameter int TAG_W = 4
) (
    input  logic             snp_valid,
    input  logic [2:0]       snp_cmd,
    input  logic [TAG_W-1:0] snp_tag,
    input  line_st_e         line_state,
    input  logic [TAG_W-1:0] line_tag,
    output logic             upd,
    output line_st_e         nxt_state,
    output logic             flush
);
    logic hit;
    assign hit = snp_valid && (line_state != LN_INV) && (line_tag == snp_tag);

    always_comb begin
        upd       = 1'b0;
        flush     = 1'b0;
        nxt_state = line_state;
        if (hit) begin
            if (snp_cmd == BC_RDMISS && line_state == LN_MOD) begin
                upd = 1'b1; flush = 1'b1; nxt_state = LN_SHR;
            end else if (snp_cmd == BC_WRMISS && line_state == LN_MOD) begin
                upd = 1'b1; flush = 1'b1; nxt_state = LN_INV;
            end else if ((snp_cmd == BC_WRMISS || snp_cmd == BC_INV) && line_state == LN_SHR) begin
                upd = 1'b1; nxt_state = LN_INV;
            end
        end
    end
endmodule

// File: rtl/msi_line_ctrl.sv
module msi_line_ctrl
    import msi_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    parameter int LINES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_valid,
    input  logic              core_write,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [DATA_W-1:0] core_wdata,
    output logic              core_ready,
    output logic [DATA_W-1:0] core_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_valid,
    output logic [2:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              snp_valid,
    input  logic [2:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_flush,
    output logic [DATA_W-1:0] snp_data
);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    ctl_st_e           state_q, state_d;
    bus_cmd_e          cmd_q, need_cmd;
    logic [ADDR_W-1:0] addr_q, need_addr;
    logic [DATA_W-1:0] data_q;
    logic              fresh_q;

    logic [IDX_W-1:0]  c_idx, s_idx;
    logic [TAG_W-1:0]  c_tag, s_tag;
    line_st_e          st_a, st_b, s_nxt, w_state;
    logic [TAG_W-1:0]  tag_a, tag_b, w_tag;
    logic [DATA_W-1:0] dat_a, dat_b, w_data;
    logic              c_match, c_hit, s_upd, we, w_tag_en, w_data_en;
    logic [IDX_W-1:0]  w_idx;

    assign c_idx = core_addr[IDX_W-1:0];
    assign c_tag = core_addr[ADDR_W-1:IDX_W];
    assign s_idx = snp_addr[IDX_W-1:0];
    assign s_tag = snp_addr[ADDR_W-1:IDX_W];

    msi_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .ra_idx(c_idx), .ra_state(st_a), .ra_tag(tag_a), .ra_data(dat_a),
        .rb_idx(s_idx), .rb_state(st_b), .rb_tag(tag_b), .rb_data(dat_b),
        .we(we), .w_idx(w_idx), .w_state(w_state),
        .w_tag_en(w_tag_en), .w_tag(w_tag), .w_data_en(w_data_en), .w_data(w_data)
    );

    msi_snoop_resp #(.TAG_W(TAG_W)) u_snoop (
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_tag(s_tag),
        .line_state(st_b), .line_tag(tag_b),
        .upd(s_upd), .nxt_state(s_nxt), .flush(snp_flush)
    );

    assign snp_data = snp_flush ? dat_b : '0;

    // Lookup and choice of the bus step the pending request needs now
    assign c_match = (st_a != LN_INV) && (tag_a == c_tag);
    assign c_hit   = core_valid && c_match && (!core_write || st_a == LN_MOD);

    always_comb begin
        if (c_match && st_a == LN_SHR && core_write) need_cmd = BC_INV;
        else if (!c_match && st_a == LN_MOD)         need_cmd = BC_WB;
        else if (core_write)                         need_cmd = BC_WRMISS;
        else                                         need_cmd = BC_RDMISS;
        need_addr = (need_cmd == BC_WB) ? {tag_a, c_idx} : core_addr;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CT_IDLE;
            cmd_q   <= BC_NONE;
            addr_q  <= '0;
            data_q  <= '0;
            fresh_q <= 1'b0;
        end else begin
            state_q <= state_d;
            fresh_q <= (state_q == CT_REQ) && bus_gnt;
            if (state_q == CT_REQ && bus_gnt) begin
                cmd_q  <= need_cmd;
                addr_q <= need_addr;
                data_q <= dat_a;
            end
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CT_IDLE: if (core_valid && !c_hit && !snp_valid) state_d = CT_REQ;
            CT_REQ:  if (bus_gnt) state_d = CT_BUSY;
            CT_BUSY: if (bus_ack) state_d = CT_IDLE;
            default: state_d = CT_IDLE;
        endcase
    end

    // Outputs and line updates
    always_comb begin
        core_ready = (state_q == CT_IDLE) && c_hit && !snp_valid;
        core_rdata = dat_a;
        bus_req    = (state_q == CT_REQ) || (state_q == CT_BUSY);
        bus_valid  = (state_q == CT_BUSY) && fresh_q;
        bus_cmd    = (state_q == CT_BUSY) ? cmd_q  : BC_NONE;
        bus_addr   = (state_q == CT_BUSY) ? addr_q : '0;
        bus_wdata  = (state_q == CT_BUSY && cmd_q == BC_WB) ? data_q : '0;

        we        = 1'b0;
        w_idx     = c_idx;
        w_state   = LN_INV;
        w_tag_en  = 1'b0;
        w_tag     = c_tag;
        w_data_en = 1'b0;
        w_data    = core_wdata;
        if (snp_valid && s_upd) begin
            we      = 1'b1;
            w_idx   = s_idx;
            w_state = s_nxt;
        end else if (state_q == CT_BUSY && bus_ack) begin
            we     = 1'b1;
            w_idx  = addr_q[IDX_W-1:0];
            w_tag  = addr_q[ADDR_W-1:IDX_W];
            w_data = bus_rdata;
            unique case (cmd_q)
                BC_INV:    w_state = LN_MOD;
                BC_WB:     w_state = LN_INV;
                BC_RDMISS: begin w_state = LN_SHR; w_tag_en = 1'b1; w_data_en = 1'b1; end
                BC_WRMISS: begin w_state = LN_MOD; w_tag_en = 1'b1; w_data_en = 1'b1; end
                default:   w_state = LN_INV;
            endcase
        end else if (core_ready && core_write) begin
            we        = 1'b1;
            w_state   = LN_MOD;
            w_data_en = 1'b1;
        end
    end

    AST_VALID_NEEDS_GNT: assert property (@(posedge clk) disable iff (!rst_n) bus_valid |-> bus_gnt) else $error("strobe without grant"); // R11
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n) bus_valid |=> !bus_valid) else $error("strobe longer than one cycle"); // R11
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n) (bus_req && !bus_ack) |=> bus_req) else $error("request dropped early"); // R10
    AST_NO_READY_WHILE_REQ: assert property (@(posedge clk) disable iff (!rst_n) bus_req |-> !core_ready) else $error("completion during bus use"); // R10
    AST_FLUSH_ON_SNOOP: assert property (@(posedge clk) disable iff (!rst_n) snp_flush |-> snp_valid) else $error("flush without snoop"); // R7
    AST_NO_SNOOP_AS_OWNER: assert property (@(posedge clk) disable iff (!rst_n) (state_q == CT_BUSY) |-> !snp_valid) else $error("snoop while owning bus"); // R9
endmodule

// File: tb/msi_line_ctrl_bench.sv
module msi_line_ctrl_bench;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 16;
    localparam int LINES  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic              cv [2];
    logic              cw [2];
    logic [ADDR_W-1:0] ca [2];
    logic [DATA_W-1:0] cwd [2];
    logic              cr [2];
    logic [DATA_W-1:0] crd [2];
    logic              breq [2];
    logic              bgnt [2];
    logic              bv [2];
    logic [2:0]        bc [2];
    logic [ADDR_W-1:0] ba [2];
    logic [DATA_W-1:0] bw [2];
    logic              back [2];
    logic [DATA_W-1:0] brd [2];
    logic              sfl [2];
    logic [DATA_W-1:0] sdat [2];

    int checks = 0;
    int errors = 0;

    msi_line_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) u_msi_line_ctrl (
        .clk(clk), .rst_n(rst_n),
        .core_valid(cv[0]), .core_write(cw[0]), .core_addr(ca[0]), .core_wdata(cwd[0]),
        .core_ready(cr[0]), .core_rdata(crd[0]),
        .bus_req(breq[0]), .bus_gnt(bgnt[0]), .bus_valid(bv[0]), .bus_cmd(bc[0]),
        .bus_addr(ba[0]), .bus_wdata(bw[0]), .bus_ack(back[0]), .bus_rdata(brd[0]),
        .snp_valid(bv[1]), .snp_cmd(bc[1]), .snp_addr(ba[1]),
        .snp_flush(sfl[0]), .snp_data(sdat[0])
    );

    msi_line_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) u_peer (
        .clk(clk), .rst_n(rst_n),
        .core_valid(cv[1]), .core_write(cw[1]), .core_addr(ca[1]), .core_wdata(cwd[1]),
        .core_ready(cr[1]), .core_rdata(crd[1]),
        .bus_req(breq[1]), .bus_gnt(bgnt[1]), .bus_valid(bv[1]), .bus_cmd(bc[1]),
        .bus_addr(ba[1]), .bus_wdata(bw[1]), .bus_ack(back[1]), .bus_rdata(brd[1]),
        .snp_valid(bv[0]), .snp_cmd(bc[0]), .snp_addr(ba[0]),
        .snp_flush(sfl[1]), .snp_data(sdat[1])
    );

    // Bus model: fixed-priority arbiter, memory, transaction log
    logic              own_v;
    int                own_i, cnt, aown, dual;
    logic [ADDR_W-1:0] aaddr;
    logic [DATA_W-1:0] mem [64];
    logic [2:0]        lg_cmd [64];
    logic [ADDR_W-1:0] lg_addr [64];
    logic [DATA_W-1:0] lg_data [64];
    int                lg_who [64];
    logic              lg_fl [64];
    int                lg_n;

    assign bgnt[0] = own_v && (own_i == 0);
    assign bgnt[1] = own_v && (own_i == 1);

    always @(negedge clk) begin
        back[0] = 1'b0;
        back[1] = 1'b0;
        if (!rst_n) begin
            own_v = 1'b0; own_i = 0; cnt = 0; aown = 0; aaddr = '0; dual = 0; lg_n = 0;
            brd[0] = '0; brd[1] = '0;
            for (int i = 0; i < 64; i++) mem[i] = 16'h0100 + 16'(i);
        end else begin
            if (cnt != 0) begin
                cnt--;
                if (cnt == 0) begin
                    back[aown] = 1'b1;
                    brd[aown]  = mem[aaddr];
                end
            end
            if (own_v && bv[own_i]) begin
                if (bc[own_i] == 3'd4) mem[ba[own_i]] = bw[own_i];
                if (sfl[1-own_i]) mem[ba[own_i]] = sdat[1-own_i];
                if (lg_n < 64) begin
                    lg_cmd[lg_n]  = bc[own_i];
                    lg_addr[lg_n] = ba[own_i];
                    lg_data[lg_n] = (bc[own_i] == 3'd4) ? bw[own_i] : (sfl[1-own_i] ? sdat[1-own_i] : '0);
                    lg_who[lg_n]  = own_i;
                    lg_fl[lg_n]   = sfl[1-own_i];
                    lg_n++;
                end
                aown = own_i; aaddr = ba[own_i]; cnt = 2;
            end
            if (bv[0] && bv[1]) dual++;
            if (own_v && !breq[own_i]) own_v = 1'b0;
            if (!own_v) begin
                if (breq[0])      begin own_v = 1'b1; own_i = 0; end
                else if (breq[1]) begin own_v = 1'b1; own_i = 1; end
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_op(input int who, input logic wr, input logic [ADDR_W-1:0] a,
                         input logic [DATA_W-1:0] d, output logic [DATA_W-1:0] rd, output int waitc);
        @(negedge clk);
        cv[who] = 1'b1; cw[who] = wr; ca[who] = a; cwd[who] = d;
        waitc = 0;
        #1;
        while (!cr[who] && waitc < 500) begin
            @(negedge clk); #1; waitc++;
        end
        if (!cr[who]) chk("R10 request never completed", 0, 1);
        rd = crd[who];
        @(posedge clk); #1;
        cv[who] = 1'b0; cw[who] = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 bus_req0 after reset", int'(breq[0]), 0);
        chk("R1 bus_req1 after reset", int'(breq[1]), 0);
        chk("R1 bus_valid after reset", int'(bv[0] | bv[1]), 0);
        chk("R1 core_ready after reset", int'(cr[0] | cr[1]), 0);
    endtask

    task automatic t_read_fill;
        logic [DATA_W-1:0] rd; int w, b;
        b = lg_n; do_op(0, 0, 6'h05, 0, rd, w);
        chk("R1 cold read goes to bus", lg_n - b, 1);
        chk("R5 read miss cmd", int'(lg_cmd[b]), 1);
        chk("R5 read miss addr", int'(lg_addr[b]), 'h05);
        chk("R5 fill data", int'(rd), 'h105);
        chk("R10 stalled while missing", int'(w >= 3), 1);
        b = lg_n; do_op(0, 0, 6'h05, 0, rd, w);
        chk("R2 read hit shared no bus", lg_n - b, 0);
        chk("R2 read hit same cycle", w, 0);
        chk("R2 read hit data", int'(rd), 'h105);
    endtask

    task automatic t_snoop_shared;
        logic [DATA_W-1:0] rd; int w, b;
        b = lg_n; do_op(1, 0, 6'h05, 0, rd, w);
        chk("R6 peer read miss cmd", int'(lg_cmd[b]), 1);
        chk("R6 no flush from shared", int'(lg_fl[b]), 0);
        chk("R6 peer data from memory", int'(rd), 'h105);
        b = lg_n; do_op(0, 0, 6'h05, 0, rd, w);
        chk("R6 shared line still hits", lg_n - b, 0);
    endtask

    task automatic t_upgrade;
        logic [DATA_W-1:0] rd; int w, b;
        b = lg_n; do_op(0, 1, 6'h05, 16'hAAAA, rd, w);
        chk("R3 write hit shared count", lg_n - b, 1);
        chk("R3 invalidate cmd", int'(lg_cmd[b]), 3);
        chk("R3 invalidate addr", int'(lg_addr[b]), 'h05);
        b = lg_n; do_op(0, 1, 6'h05, 16'hAAAB, rd, w);
        chk("R2 write hit modified no bus", lg_n - b, 0);
        chk("R2 write hit same cycle", w, 0);
        b = lg_n; do_op(1, 0, 6'h05, 0, rd, w);
        chk("R8 invalidated peer misses", lg_n - b, 1);
        chk("R7 flush on snooped read of M", int'(lg_fl[b]), 1);
        chk("R7 requester gets dirty data", int'(rd), 'hAAAB);
        chk("R7 memory updated by flush", int'(mem[5]), 'hAAAB);
        b = lg_n; do_op(0, 1, 6'h05, 16'hAAAC, rd, w);
        chk("R7 line downgraded to S needs invalidate", int'(lg_cmd[b]), 3);
    endtask

    task automatic t_victim;
        logic [DATA_W-1:0] rd; int w, b;
        b = lg_n; do_op(0, 0, 6'h09, 0, rd, w);
        chk("R4 two transactions", lg_n - b, 2);
        chk("R4 write-back first", int'(lg_cmd[b]), 4);
        chk("R4 write-back victim addr", int'(lg_addr[b]), 'h05);
        chk("R4 write-back victim data", int'(lg_data[b]), 'hAAAC);
        chk("R4 miss after write-back", int'(lg_cmd[b+1]), 1);
        chk("R4 memory holds victim", int'(mem[5]), 'hAAAC);
        chk("R4 new line data", int'(rd), 'h109);
    endtask

    task automatic t_write_miss;
        logic [DATA_W-1:0] rd; int w, b;
        b = lg_n; do_op(1, 1, 6'h09, 16'hBBBB, rd, w);
        chk("R5 write miss count", lg_n - b, 1);
        chk("R5 write miss cmd", int'(lg_cmd[b]), 2);
        chk("R8 shared snooper gives no data", int'(lg_fl[b]), 0);
        b = lg_n; do_op(1, 1, 6'h09, 16'hBBBC, rd, w);
        chk("R5 write-miss fill is modified", lg_n - b, 0);
        b = lg_n; do_op(0, 0, 6'h09, 0, rd, w);
        chk("R8 write miss invalidated shared copy", lg_n - b, 1);
        chk("R7 flush to reader", int'(rd), 'hBBBC);
        b = lg_n; do_op(0, 1, 6'h09, 16'hCCCC, rd, w);
        chk("R3 upgrade after sharing", int'(lg_cmd[b]), 3);
        b = lg_n; do_op(1, 1, 6'h09, 16'hDDDD, rd, w);
        chk("R8 write miss against M", int'(lg_cmd[b]), 2);
        chk("R8 modified owner flushes", int'(lg_fl[b]), 1);
        chk("R8 flushed data to memory", int'(mem[9]), 'hCCCC);
        b = lg_n; do_op(0, 0, 6'h09, 0, rd, w);
        chk("R8 old owner was invalidated", lg_n - b, 1);
        chk("R8 reader sees last write", int'(rd), 'hDDDD);
    endtask

    task automatic t_race;
        logic [DATA_W-1:0] r0, r1, rd; int w0, w1, w, b;
        do_op(0, 0, 6'h02, 0, rd, w);
        do_op(1, 0, 6'h02, 0, rd, w);
        b = lg_n;
        fork
            do_op(0, 1, 6'h02, 16'h1111, r0, w0);
            do_op(1, 1, 6'h02, 16'h2222, r1, w1);
        join
        chk("R9 race transaction count", lg_n - b, 2);
        chk("R9 winner invalidates", int'(lg_cmd[b]), 3);
        chk("R9 winner is cache 0", lg_who[b], 0);
        chk("R9 loser turns to write miss", int'(lg_cmd[b+1]), 2);
        chk("R9 loser is cache 1", lg_who[b+1], 1);
        do_op(0, 0, 6'h02, 0, rd, w);
        chk("R9 final value is later write", int'(rd), 'h2222);
        chk("R9 never two bus strobes", dual, 0);
    endtask

    initial begin
        for (int i = 0; i < 2; i++) begin
            cv[i] = 1'b0; cw[i] = 1'b0; ca[i] = '0; cwd[i] = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        t_reset();
        t_read_fill();
        t_snoop_shared();
        t_upgrade();
        t_victim();
        t_write_miss();
        t_race();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule